// File: doc/BRIEF.md
# Ethernet Receive Deframer with Pad Stripping

This block sits behind the line decoder of an Ethernet receiver. It accepts the recovered serial stream one bit at a time, qualified by a bit-valid strobe and framed by carrier sense. When carrier comes up, it throws away the first eight bits. It then hunts for the start frame delimiter and packs every following bit into bytes, least significant bit first. The bytes go to the receive FIFO side, each with a one-cycle valid pulse, and the first and last bytes of the frame are flagged.

While a frame is arriving, the block picks up the two-byte length/type field at byte offsets 12 and 13, most significant byte first. Pad stripping is enabled by a control input. If it is enabled and the field holds a length below the 46-byte minimum data size, only the 14 header bytes and that many data bytes are forwarded. The pad and the received FCS are dropped. A field value of 46 or more, which includes any type value above 1500, never causes stripping. When carrier drops, the frame ends. The block holds back one byte so that the final forwarded byte can carry the last flag.

Top module: `eth_rx_deframer`

## Requirements
- R1: After reset, and whenever no frame is in progress, rx_vld, rx_first and rx_last are low.
- R2: After rx_crs rises, the first 8 qualified bits are discarded. A delimiter pattern inside them does not start a frame.
- R3: After those 8 bits, the delimiter is the bit sequence 1,0,1,0,1,0,1,1 in arrival order (byte 0xD5). Every qualified bit after it is frame content.
- R4: Frame bits are packed least significant bit first. Bytes are forwarded in arrival order, each with a single-cycle rx_vld pulse.
- R5: rx_first is high with the first forwarded byte of a frame and with no other byte.
- R6: When rx_crs is sampled low during a frame, the held byte is forwarded on the next cycle with rx_last high. A partial byte is discarded.
- R7: When strip_en is high at byte 13 and the length field L (byte 12 is the high byte, byte 13 the low byte) is below 46, only bytes 0 through 13+L are forwarded.
- R8: A length/type value of 46 or more is never stripped, including type values above 1500. Every received byte is forwarded.
- R9: With strip_en low, every received byte of a short frame is forwarded unchanged.
- R10: A cycle with rx_bit_vld low consumes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Decoded serial data bit |
| rx_bit_vld | input | 1 | rx_bit holds a new bit this cycle |
| rx_crs | input | 1 | Carrier sense; frame boundary |
| strip_en | input | 1 | Enables pad and FCS removal for short length values |
| rx_data | output | 8 | Forwarded byte |
| rx_vld | output | 1 | rx_data valid, one cycle per byte |
| rx_first | output | 1 | First byte of the frame |
| rx_last | output | 1 | Last byte of the frame |

## Verification
The hardest case to bring about is a delimiter pattern arriving inside the eight-bit discard window. A decoder that begins hunting too early would lock onto it and shift every following byte. The bench provokes this by sending the delimiter itself as the first eight bits after carrier rises. It follows with further preamble and a genuine delimiter, then checks that the forwarded frame starts at the genuine one. The other hard case is carrier loss in the middle of a byte. It is reached by sending three stray bits after the last whole byte before dropping carrier. A sweep of length values from 0 to 50 crosses the strip boundary at 46 with stripping both on and off.

// File: rtl/eth_rx_deframer.sv
module eth_rx_deframer #(
  parameter int MIN_DATA  = 46,
  parameter int HDR_BYTES = 14,
  parameter int IDX_W     = 16,
  parameter logic [7:0] SFD = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_bit_vld,
  input  logic       rx_crs,
  input  logic       strip_en,
  output logic [7:0] rx_data,
  output logic       rx_vld,
  output logic       rx_first,
  output logic       rx_last
);
  localparam int LIM_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LEN_HI = IDX_W'(HDR_BYTES - 2);
  localparam logic [IDX_W-1:0] LEN_LO = IDX_W'(HDR_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SKIP, S_HUNT, S_DATA} st_t;
  st_t st;

  logic [7:0]       sh, hi_q, pend_q;
  logic [2:0]       bcnt;
  logic [IDX_W-1:0] idx;
  logic [15:0]      len_q;
  logic             strip_q, pend_v, pend_first, first_todo;

  wire [7:0]       sh_n     = {rx_bit, sh[7:1]};
  wire [15:0]      len_n    = {hi_q, sh_n};
  wire [LIM_W-1:0] keep_lim = LIM_W'(HDR_BYTES) + LIM_W'(len_q);
  wire             keep     = !strip_q || (LIM_W'(idx) < keep_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sh <= '0;
      hi_q <= '0;
      pend_q <= '0;
      bcnt <= '0;
      idx <= '0;
      len_q <= '0;
      strip_q <= 1'b0;
      pend_v <= 1'b0;
      pend_first <= 1'b0;
      first_todo <= 1'b0;
      rx_data <= '0;
      rx_vld <= 1'b0;
      rx_first <= 1'b0;
      rx_last <= 1'b0;
    end else begin
      rx_vld <= 1'b0;
      rx_first <= 1'b0;
      rx_last <= 1'b0;
      case (st)
        S_IDLE: if (rx_crs) begin
          st <= S_SKIP;
          bcnt <= '0;
        end
        S_SKIP:
          if (!rx_crs) st <= S_IDLE;
          else if (rx_bit_vld) begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st <= S_HUNT;
              sh <= '0;
            end
          end
        S_HUNT:
          if (!rx_crs) st <= S_IDLE;
          else if (rx_bit_vld) begin
            sh <= sh_n;
            if (sh_n == SFD) begin
              st <= S_DATA;
              bcnt <= '0;
              idx <= '0;
              strip_q <= 1'b0;
              pend_v <= 1'b0;
              first_todo <= 1'b1;
            end
          end
        S_DATA:
          if (!rx_crs) begin
            st <= S_IDLE;
            if (pend_v) begin
              rx_data <= pend_q;
              rx_vld <= 1'b1;
              rx_first <= pend_first;
              rx_last <= 1'b1;
            end
            pend_v <= 1'b0;
          end else if (rx_bit_vld) begin
            sh <= sh_n;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (idx != '1) idx <= idx + 1'b1;
              if (idx == LEN_HI) hi_q <= sh_n;
              if (idx == LEN_LO) begin
                len_q <= len_n;
                strip_q <= strip_en && (len_n < 16'(MIN_DATA));
              end
              if (keep) begin
                if (pend_v) begin
                  rx_data <= pend_q;
                  rx_vld <= 1'b1;
                  rx_first <= pend_first;
                end
                pend_q <= sh_n;
                pend_v <= 1'b1;
                pend_first <= first_todo;
                first_todo <= 1'b0;
              end
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_rx_deframer_chk.sv
module eth_rx_deframer_chk #(
  parameter int HDR_BYTES = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_crs,
  input logic        rx_bit_vld,
  input logic        rx_vld,
  input logic        rx_first,
  input logic        rx_last,
  input logic        strip_q,
  input logic [15:0] len_q
);
  logic [16:0] out_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) out_cnt <= '0;
    else if (rx_vld) out_cnt <= rx_first ? 17'd1 : out_cnt + 17'd1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_first || rx_last) |-> rx_vld);

  p_first_nonrepeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && rx_first |=> !rx_first);

  p_byte_from_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && !rx_last |-> $past(rx_crs) && $past(rx_bit_vld));

  p_last_on_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> !$past(rx_crs));

  p_strip_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && !rx_first && strip_q |-> out_cnt < 17'(HDR_BYTES) + 17'(len_q));
endmodule

bind eth_rx_deframer eth_rx_deframer_chk #(.HDR_BYTES(HDR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_crs(rx_crs), .rx_bit_vld(rx_bit_vld),
  .rx_vld(rx_vld), .rx_first(rx_first), .rx_last(rx_last),
  .strip_q(strip_q), .len_q(len_q)
);

// File: tb/test_eth_rx_deframer.sv
module test_eth_rx_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_bit_vld = 1'b0, rx_crs = 1'b0, strip_en = 1'b0;
  logic [7:0] rx_data;
  logic rx_vld, rx_first, rx_last;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_d [MAXB];
  logic [7:0] got_d [MAXB];
  logic got_f [MAXB];
  logic got_l [MAXB];
  int got_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_deframer i_eth_rx_deframer (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
    .rx_crs(rx_crs), .strip_en(strip_en), .rx_data(rx_data),
    .rx_vld(rx_vld), .rx_first(rx_first), .rx_last(rx_last)
  );

  always @(negedge clk) if (rx_vld) begin
    if (got_n < MAXB) begin
      got_d[got_n] = rx_data;
      got_f[got_n] = rx_first;
      got_l[got_n] = rx_last;
    end
    got_n++;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b, bit gap);
    @(negedge clk);
    rx_bit = b;
    rx_bit_vld = 1'b1;
    if (gap) begin
      @(negedge clk);
      rx_bit_vld = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit gap);
    for (int i = 0; i < 8; i++) send_bit(b[i], gap);
  endtask

  task automatic frame(logic [7:0] junk, int pre, int nb, int extra, bit gap);
    @(posedge clk);
    got_n = 0;
    @(negedge clk);
    rx_crs = 1'b1;
    rx_bit_vld = 1'b0;
    send_byte(junk, gap);
    for (int i = 0; i < pre; i++) send_byte(8'h55, gap);
    send_byte(8'hD5, gap);
    for (int i = 0; i < nb; i++) send_byte(exp_d[i], gap);
    for (int i = 0; i < extra; i++) send_bit(1'b1, gap);
    @(negedge clk);
    rx_crs = 1'b0;
    rx_bit_vld = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fill(int nb, int len, int seed);
    for (int i = 0; i < nb; i++) exp_d[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    exp_d[12] = 8'(len >> 8);
    exp_d[13] = 8'(len & 255);
  endtask

  task automatic verify(string tag, int exp_n);
    int bad_d, bad_f, bad_l;
    bad_d = 0; bad_f = 0; bad_l = 0;
    chk({tag, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < MAXB; i++) begin
      if (got_d[i] !== exp_d[i]) bad_d++;
      if (got_f[i] !== (i == 0)) bad_f++;
      if (got_l[i] !== (i == exp_n - 1)) bad_l++;
    end
    chk({tag, " R3 R4 byte data mismatches"}, bad_d, 0);
    chk({tag, " R5 first flag mismatches"}, bad_f, 0);
    chk({tag, " R6 last flag mismatches"}, bad_l, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb, en;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(rx_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle outputs", int'(rx_vld) + int'(rx_first) + int'(rx_last) + got_n, 0);

    for (int s = 0; s < 2; s++) begin
      for (int len = 0; len <= 50; len++) begin
        strip_en = s[0];
        nb = 14 + ((len < 46) ? 46 : len) + 4;
        fill(nb, len, len + s);
        en = (s == 1 && len < 46) ? 14 + len : nb;
        frame(8'h0F, 7, nb, 0, (len % 7) == 3);
        if (s == 1 && len < 46) verify("R7 strip short", en);
        else if (s == 1) verify("R8 no strip at or above min", en);
        else verify(((len % 7) == 3) ? "R9 R10 strip off gapped" : "R9 strip off", en);
      end
    end

    strip_en = 1'b1;
    fill(64, 16'h0800, 3);
    frame(8'h0F, 7, 64, 0, 1'b0);
    verify("R8 type value", 64);

    strip_en = 1'b0;
    fill(20, 20, 9);
    for (int i = 0; i < 20; i++) if (exp_d[i] == 8'hD5) exp_d[i] = 8'h11;
    frame(8'hD5, 2, 20, 0, 1'b0);
    verify("R2 delimiter in skip window", 20);

    fill(24, 20, 4);
    frame(8'h0F, 7, 24, 3, 1'b0);
    verify("R6 partial byte dropped", 24);

    strip_en = 1'b1;
    fill(64, 0, 6);
    frame(8'h0F, 7, 64, 0, 1'b1);
    verify("R7 R10 zero length gapped", 14);

    repeat (5) @(negedge clk);
    chk("R1 quiet after frames", int'(rx_vld), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule